// File: doc/BRIEF.md
# Display Pixel Input FIFO with Unpacker

This block sits between a DMA engine and a display pipeline. The DMA side delivers 64-bit words through a valid/ready write port, and the words are queued in a sixteen-entry store. Each entry holds packed pixels. A request output tells the DMA engine when a fixed burst of four words (32 bytes) will fit, and it stays raised until that burst has been delivered.

On the read side, the entry at the head of the queue is cut into pixels of a width chosen by the bits-per-pixel input. The cut starts at the least significant bits of the entry. Pixels of 1, 2, 4 or 8 bits leave the block marked as palette indices. Pixels of 16 bits leave marked as direct colour, so the pipeline can route them past the palette.

Back-pressure works on both streams as follows. A write transfers on a rising edge only when `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the store is full. A pixel transfers on a rising edge only when `px_valid` and `px_ready` are both high. While `px_ready` is low, the offered pixel is held unchanged. `px_valid` is low while the store is empty. A synchronous `clear` at frame start empties the store and returns the unpack position to pixel 0. `bpp_sel` must only change while the store is empty.

Top module: `pix_infifo`

## Requirements
- R1: After reset and after a clear, `px_valid` is 0, `wr_ready` is 1 and `svc_req` is 1.
- R2: The store holds exactly 16 entries. With no reads, 16 writes are accepted and then `wr_ready` goes low. A word offered while `wr_ready` is low is not stored and never appears at the pixel output.
- R3: When no burst is in progress, `svc_req` is 1 if at least 4 entries are free and 0 if fewer than 4 are free.
- R4: A write accepted while `svc_req` is 1 and no burst is in progress starts a burst. `svc_req` then stays 1 until that write and the three writes after it have been accepted, even while fewer than 4 entries are free.
- R5: Entries reach the pixel output in the order in which they were written.
- R6: Pixel k of an entry is taken from entry bits [k*w +: w], where w is the pixel width. The pixels are sent in order k = 0 to 64/w-1. After the last pixel of an entry, the next entry begins.
- R7: The `bpp_sel` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel. Each pixel appears zero-extended on `px_data` with `px_direct` = 0, meaning a palette index.
- R8: The `bpp_sel` code 4 selects 16 bits per pixel. Each pixel is the full `px_data`, with `px_direct` = 1, meaning a direct colour.
- R9: `px_valid` is 0 while the store is empty. While `px_valid` is 1 and `px_ready` is 0, `px_valid` stays 1 and `px_data` stays unchanged.
- R10: A clear discards all stored entries, any write offered in the same cycle, and the partly read entry. The first pixel after a clear is pixel 0 of the next word written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous frame-start clear |
| bpp_sel | input | 3 | Pixel size code: 0=1, 1=2, 2=4, 3=8, 4=16 bits |
| wr_valid | input | 1 | DMA word offered |
| wr_ready | output | 1 | Store can accept a word |
| wr_data | input | 64 | DMA word, packed pixels |
| svc_req | output | 1 | Request for a four-word burst |
| px_valid | output | 1 | Pixel offered |
| px_ready | input | 1 | Pipeline takes the pixel |
| px_data | output | 16 | Pixel value, zero-extended |
| px_direct | output | 1 | 1 = direct colour, 0 = palette index |

## Verification
- Write timing: `wr_ready` and `svc_req` change one rising edge after an accepted write. The bench therefore samples them 1 ns after the edge that accepted the word.
- Read timing: the head pixel is presented in the same cycle in which the store is non-empty, and an accepted pixel moves the output on by one pixel at the next edge. Each pixel is compared 1 ns after a falling edge, before `px_ready` is raised for the following rising edge.
- Burst hold: this is checked at the exact write that leaves only three entries free, where a plain free-space compare would already have dropped the request.
- Clear: its effect is due one edge after it, and the bench samples at that point.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
  localparam int ENTRY_W = 64;
  localparam int PIX_W   = 16;
  localparam int LG_MAX  = 4;

  typedef enum logic [2:0] {
    BPP1  = 3'd0,
    BPP2  = 3'd1,
    BPP4  = 3'd2,
    BPP8  = 3'd3,
    BPP16 = 3'd4
  } bpp_e;

  // log2 of pixel width; codes above the widest clamp to it
  function automatic logic [2:0] width_log2(input logic [2:0] code);
    return (code > 3'(LG_MAX)) ? 3'(LG_MAX) : code;
  endfunction
endpackage

// File: rtl/pxf_store.sv
module pxf_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;
  assign rdata   = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clear) |=> full);
endmodule

// File: rtl/pxf_watermark.sv
module pxf_watermark #(
  parameter int DEPTH = 16,
  parameter int BURST = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int BW = $clog2(BURST) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] count,
  input  logic          wr_fire,
  output logic          req
);
  logic [BW-1:0] left;
  logic [CW-1:0] free;
  logic          room;

  assign free = CW'(DEPTH) - count;
  assign room = (free >= CW'(BURST));
  assign req  = (left != '0) || room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left <= '0;
    else if (clear)   left <= '0;
    else if (wr_fire) begin
      if (left != '0) left <= left - 1'b1;
      else if (room)  left <= BW'(BURST - 1);
    end
  end

  // R4
  req_drop_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> $past(wr_fire));
endmodule

// File: rtl/pxf_unpack.sv
module pxf_unpack
  import pxf_pkg::*;
#(
  localparam int IW = $clog2(ENTRY_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [2:0]         bpp_sel,
  input  logic [ENTRY_W-1:0] entry,
  input  logic               entry_valid,
  input  logic               px_ready,
  output logic               px_valid,
  output logic [PIX_W-1:0]   px_data,
  output logic               px_direct,
  output logic               pop
);
  logic [2:0]         lg;
  logic [4:0]         pw;
  logic [IW-1:0]      idx, last, shamt;
  logic [ENTRY_W-1:0] sh;
  logic [PIX_W-1:0]   mask;
  logic               fire;

  assign lg        = width_log2(bpp_sel);
  assign pw        = 5'(1) << lg;
  assign last      = IW'((ENTRY_W >> lg) - 1);
  assign shamt     = IW'(idx << lg);
  assign sh        = entry >> shamt;
  assign mask      = ~({PIX_W{1'b1}} << pw);
  assign px_valid  = entry_valid;
  assign px_data   = sh[PIX_W-1:0] & mask;
  assign px_direct = (lg == 3'(LG_MAX));
  assign fire      = px_valid && px_ready;
  assign pop       = fire && (idx == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (fire)  idx <= (idx == last) ? '0 : idx + 1'b1;
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready && !clear) |=> (px_valid && $stable(px_data)));
endmodule

// File: rtl/pix_infifo.sv
module pix_infifo
  import pxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BURST = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [2:0]         bpp_sel,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic               svc_req,
  output logic               px_valid,
  input  logic               px_ready,
  output logic [PIX_W-1:0]   px_data,
  output logic               px_direct
);
  logic [ENTRY_W-1:0] head;
  logic [CW-1:0]      count;
  logic               full, empty, pop, wr_fire;

  assign wr_ready = !full;
  assign wr_fire  = wr_valid && wr_ready && !clear;

  pxf_store #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .push(wr_fire), .wdata(wr_data),
    .pop(pop), .rdata(head),
    .count(count), .full(full), .empty(empty)
  );

  pxf_watermark #(.DEPTH(DEPTH), .BURST(BURST)) u_wm (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .count(count), .wr_fire(wr_fire), .req(svc_req)
  );

  pxf_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .clear(clear), .bpp_sel(bpp_sel),
    .entry(head), .entry_valid(!empty), .px_ready(px_ready),
    .px_valid(px_valid), .px_data(px_data), .px_direct(px_direct),
    .pop(pop)
  );

  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> (!px_valid && wr_ready));
endmodule

// File: tb/tb_pix_infifo.sv
`timescale 1ns/1ps
module tb_pix_infifo;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        clear = 0;
  logic [2:0]  bpp_sel = 3'd4;
  logic        wr_valid = 0;
  logic        wr_ready;
  logic [63:0] wr_data = '0;
  logic        svc_req;
  logic        px_valid;
  logic        px_ready = 0;
  logic [15:0] px_data;
  logic        px_direct;

  int n_chk = 0;
  int n_bad = 0;
  bit accepted;

  always #2.5 clk = ~clk;

  pix_infifo dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .bpp_sel(bpp_sel),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .svc_req(svc_req), .px_valid(px_valid), .px_ready(px_ready),
    .px_data(px_data), .px_direct(px_direct)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] word_of(input int i);
    return 64'h0123_4567_89AB_CDEF * 64'(i + 1) + 64'(i * 7);
  endfunction

  task automatic push(input logic [63:0] d);
    @(negedge clk);
    wr_valid = 1; wr_data = d;
    #1 accepted = wr_ready;
    @(posedge clk);
    #1 wr_valid = 0;
  endtask

  task automatic pop_px(input logic [15:0] exp, input bit dir, input string tag);
    @(negedge clk);
    #1;
    chk(px_valid == 1'b1, {tag, " valid"}, 64'(px_valid), 64'd1);
    chk(px_data == exp, {tag, " data"}, 64'(px_data), 64'(exp));
    chk(px_direct == dir, {tag, " direct"}, 64'(px_direct), 64'(dir));
    px_ready = 1;
    @(posedge clk);
    #1 px_ready = 0;
  endtask

  task automatic do_clear(input bit with_write, input logic [63:0] d);
    @(negedge clk);
    clear = 1; wr_valid = with_write; wr_data = d;
    @(posedge clk);
    #1 clear = 0; wr_valid = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(!px_valid, "R1 px_valid after reset", 64'(px_valid), 0);
    chk(wr_ready, "R1 wr_ready after reset", 64'(wr_ready), 1);
    chk(svc_req, "R1 svc_req after reset", 64'(svc_req), 1);
  endtask

  task automatic t_fill_burst;
    do_clear(0, '0);
    bpp_sel = 3'd4;
    for (int i = 0; i < 12; i++) begin
      push(word_of(i));
      chk(accepted, "R2 accept fill", 64'(accepted), 1);
    end
    chk(svc_req, "R3 req with four free", 64'(svc_req), 1);
    for (int i = 12; i < 16; i++) begin
      push(word_of(i));
      chk(accepted, "R2 accept burst", 64'(accepted), 1);
      if (i < 15) chk(svc_req, "R4 req held in burst", 64'(svc_req), 1);
    end
    chk(!svc_req, "R3 req low when full", 64'(svc_req), 0);
    chk(!wr_ready, "R2 ready low at 16", 64'(wr_ready), 0);
    push(64'hDEAD_BEEF_DEAD_BEEF);
    chk(!accepted, "R2 refused when full", 64'(accepted), 0);
    for (int e = 0; e < 16; e++) begin
      logic [63:0] w = word_of(e);
      for (int k = 0; k < 4; k++)
        pop_px(w[k*16 +: 16], 1'b1, "R5 R8 order direct");
      #0;
      if (e < 3) chk(!svc_req, "R3 req low with under four free", 64'(svc_req), 0);
      if (e == 3) chk(svc_req, "R3 req back at four free", 64'(svc_req), 1);
    end
    chk(!px_valid, "R2 R9 empty after 16 entries", 64'(px_valid), 0);
  endtask

  task automatic t_unpack(input int code);
    logic [63:0] w = 64'hF0E1_D2C3_B4A5_9687 ^ 64'(code * 64'h1357_9BDF);
    int width = 1 << code;
    do_clear(0, '0);
    bpp_sel = 3'(code);
    push(w);
    for (int k = 0; k < 64 / width; k++) begin
      logic [63:0] m = (w >> (k * width)) & ((64'd1 << width) - 1);
      pop_px(m[15:0], 1'b0, "R6 R7 unpack");
    end
    #1;
    chk(!px_valid, "R6 entry ends after 64/w pixels", 64'(px_valid), 0);
  endtask

  task automatic t_stall;
    logic [15:0] d0;
    do_clear(0, '0);
    bpp_sel = 3'd3;
    push(64'h1122_3344_5566_77AB);
    @(negedge clk); #1 d0 = px_data;
    repeat (3) @(posedge clk);
    #1;
    chk(px_valid, "R9 valid held in stall", 64'(px_valid), 1);
    chk(px_data == d0 && d0 == 16'h00AB, "R9 data held in stall", 64'(px_data), 64'h00AB);
    pop_px(16'h00AB, 1'b0, "R9 after stall");
    pop_px(16'h0077, 1'b0, "R9 next after stall");
  endtask

  task automatic t_clear;
    do_clear(0, '0);
    bpp_sel = 3'd4;
    push(64'hAAAA_BBBB_CCCC_DDDD);
    push(64'h1111_2222_3333_4444);
    pop_px(16'hDDDD, 1'b1, "R10 pre clear");
    do_clear(1, 64'h9999_8888_7777_6666);
    chk(!px_valid, "R10 empty after clear", 64'(px_valid), 0);
    chk(svc_req && wr_ready, "R1 req and ready after clear", 64'({svc_req, wr_ready}), 3);
    push(64'h5555_4444_3333_2222);
    pop_px(16'h2222, 1'b1, "R10 position reset");
    pop_px(16'h3333, 1'b1, "R10 second pixel");
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_fill_burst();
    for (int c = 0; c < 4; c++) t_unpack(c);
    t_stall();
    t_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule